// File: doc/BRIEF.md
# Armed Edge-Pair Capture Unit

This unit measures one pulse on an external signal against an 8-bit free-running counter. Software arms it by writing 1 to a start bit. The unit then waits for a rising edge on the external signal and stores the counter value at that edge in a rise register. It then waits for the next falling edge and stores the counter value in a fall register. After the falling-edge capture, the start bit clears by itself and the unit goes idle until software arms it again.

The external signal passes through a two-flop synchroniser and then through an edge detector before it reaches the sequencer. Software reads the start bit and both capture registers through a small combinational read port. The capture registers are visible only when two mode-select inputs are both low. Software computes the pulse width from the two captured values; this unit does not.

Top module: `edge_pair_capture`

## Requirements
- R1: After reset, the rise and fall capture registers both read 0x00 and the start bit reads 0.
- R2: While the start bit is 0, edges on the external signal leave both capture registers unchanged.
- R3: After arming, the first rising edge of the external signal loads the counter into the rise register. The rise register is at read address 1.
- R4: After the rise capture, the next falling edge loads the counter into the fall register. The fall register is at read address 2.
- R5: The start bit reads 0 again once the fall capture completes, and later edges change neither register until the next arm. The start bit is bit 0 at read address 0, and the other bits of that address read 0.
- R6: A falling edge that arrives after arming but before the rise capture is ignored. The fall register keeps its value and the start bit stays 1.
- R7: Writing 1 to the start bit while a capture sequence is in progress restarts the sequence at the wait-for-rising-edge step. The start bit stays 1, and the next falling edge is ignored until a new rise capture has been taken.
- R8: Writing 0 to the start bit aborts a sequence in progress. Later edges then change neither capture register.
- R9: Reads at addresses 1 and 2 return 0x00 whenever either mode-select input is 1. The read of the start bit is not affected by the mode-select inputs. Address 3 always reads 0x00.
- R10: A transition of the external signal that is first sampled at clock edge N is captured with the counter value present at clock edge N+2. This delay comes from the two synchroniser flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| cnt_i | input | 8 | Value of the free-running counter |
| ext_i | input | 1 | Asynchronous external signal to be measured |
| arm_we_i | input | 1 | Write strobe for the start bit |
| arm_wdata_i | input | 1 | Value to write to the start bit |
| rd_addr_i | input | 2 | Read address: 0 = start bit, 1 = rise register, 2 = fall register |
| sel_x_i | input | 1 | Mode-select input; when 1, the capture registers are hidden |
| sel_y_i | input | 1 | Mode-select input; when 1, the capture registers are hidden |
| rd_data_o | output | 8 | Read data |

## Verification
The restart case is the hardest one to reach from the ports. It needs a second arm write that lands after a rise capture and while the external signal is still high, so that the falling edge which follows arrives in the wait-for-rise step and has to be dropped. The bench raises the input, waits until the rise capture has been taken, rewrites the start bit, and only then lowers the input. It then checks that the fall register is unchanged and that the start bit is still set. The bench drives the counter on every clock. Each capture expectation is the counter value at the second clock after the transition was driven, so any change in the synchroniser latency shows up as a wrong capture value.

// File: rtl/epc_pkg.sv
package epc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_RISE = 2'd1,
        ST_WAIT_FALL = 2'd2
    } epc_state_e;

    localparam int unsigned ADDR_W      = 2;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
    localparam logic [ADDR_W-1:0] A_RISE = 2'd1;
    localparam logic [ADDR_W-1:0] A_FALL = 2'd2;

endpackage

// File: rtl/epc_edge_sync.sv
module epc_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_reg_t;

    sync_reg_t r_d, r_q;

    always_comb begin
        r_d          = r_q;
        r_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            r_d.chain[i] = r_q.chain[i-1];
        end
        r_d.last = r_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rise_o = r_q.chain[STAGES-1] & ~r_q.last;
    assign fall_o = ~r_q.chain[STAGES-1] & r_q.last;

    AST_EDGE_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o); // R10

    AST_FALL_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o); // R10

endmodule

// File: rtl/epc_seq.sv
module epc_seq
    import epc_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             arm_we_i,
    input  logic             arm_wdata_i,
    output logic             armed_o,
    output logic [CNT_W-1:0] rise_cap_o,
    output logic [CNT_W-1:0] fall_cap_o
);

    typedef struct packed {
        epc_state_e       state;
        logic [CNT_W-1:0] rise_cap;
        logic [CNT_W-1:0] fall_cap;
    } seq_reg_t;

    seq_reg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (arm_we_i) begin
            // a software write wins over any edge in the same cycle
            s_d.state = arm_wdata_i ? ST_WAIT_RISE : ST_IDLE;
        end else begin
            unique case (s_q.state)
                ST_WAIT_RISE: begin
                    if (rise_i) begin
                        s_d.rise_cap = cnt_i;
                        s_d.state    = ST_WAIT_FALL;
                    end
                end
                ST_WAIT_FALL: begin
                    if (fall_i) begin
                        s_d.fall_cap = cnt_i;
                        s_d.state    = ST_IDLE;
                    end
                end
                default: s_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{state: ST_IDLE, rise_cap: '0, fall_cap: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign armed_o    = (s_q.state != ST_IDLE);
    assign rise_cap_o = s_q.rise_cap;
    assign fall_cap_o = s_q.fall_cap;

    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.state == ST_IDLE && !arm_we_i) |=> ($stable(rise_cap_o) && $stable(fall_cap_o))); // R2

    AST_RISE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.state == ST_WAIT_RISE && rise_i && !arm_we_i)
            |=> (rise_cap_o == $past(cnt_i) && s_q.state == ST_WAIT_FALL)); // R3

    AST_FALL_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.state == ST_WAIT_FALL && fall_i && !arm_we_i)
            |=> (fall_cap_o == $past(cnt_i) && !armed_o)); // R4

    AST_EARLY_FALL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.state == ST_WAIT_RISE && fall_i && !arm_we_i) |=> ($stable(fall_cap_o) && armed_o)); // R6

    AST_ARM_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm_we_i && arm_wdata_i) |=> (s_q.state == ST_WAIT_RISE)); // R7

    AST_ARM_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm_we_i && !arm_wdata_i) |=> !armed_o); // R8

endmodule

// File: rtl/epc_rd_mux.sv
module epc_rd_mux
    import epc_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sel_x_i,
    input  logic              sel_y_i,
    input  logic              armed_i,
    input  logic [CNT_W-1:0]  rise_cap_i,
    input  logic [CNT_W-1:0]  fall_cap_i,
    output logic [CNT_W-1:0]  data_o
);

    logic cap_visible;

    assign cap_visible = ~(sel_x_i | sel_y_i);

    always_comb begin
        data_o = '0;
        unique case (addr_i)
            A_STAT:  data_o[0] = armed_i;
            A_RISE:  data_o    = cap_visible ? rise_cap_i : '0;
            A_FALL:  data_o    = cap_visible ? fall_cap_i : '0;
            default: data_o    = '0;
        endcase
    end

endmodule

// File: rtl/edge_pair_capture.sv
module edge_pair_capture
    import epc_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              ext_i,
    input  logic              arm_we_i,
    input  logic              arm_wdata_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              sel_x_i,
    input  logic              sel_y_i,
    output logic [CNT_W-1:0]  rd_data_o
);

    logic             rise_p, fall_p, armed;
    logic [CNT_W-1:0] rise_cap, fall_cap;

    epc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(ext_i),
        .rise_o (rise_p),
        .fall_o (fall_p)
    );

    epc_seq #(.CNT_W(CNT_W)) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cnt_i      (cnt_i),
        .rise_i     (rise_p),
        .fall_i     (fall_p),
        .arm_we_i   (arm_we_i),
        .arm_wdata_i(arm_wdata_i),
        .armed_o    (armed),
        .rise_cap_o (rise_cap),
        .fall_cap_o (fall_cap)
    );

    epc_rd_mux #(.CNT_W(CNT_W)) u_rd (
        .addr_i    (rd_addr_i),
        .sel_x_i   (sel_x_i),
        .sel_y_i   (sel_y_i),
        .armed_i   (armed),
        .rise_cap_i(rise_cap),
        .fall_cap_i(fall_cap),
        .data_o    (rd_data_o)
    );

    AST_BLOCKED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((sel_x_i || sel_y_i) && (rd_addr_i == A_RISE || rd_addr_i == A_FALL))
            |-> (rd_data_o == '0)); // R9

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_addr_i == A_STAT) |-> (rd_data_o[CNT_W-1:1] == '0)); // R5

endmodule

// File: tb/edge_pair_capture_tb.sv
module edge_pair_capture_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cnt = 8'd0;
    logic       ext = 1'b0;
    logic       we = 1'b0;
    logic       wd = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       sx = 1'b0;
    logic       sy = 1'b0;
    logic [7:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_rise = 8'd0;
    logic [7:0] exp_fall = 8'd0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 8'd1;

    edge_pair_capture u_dut (
        .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .ext_i(ext),
        .arm_we_i(we), .arm_wdata_i(wd), .rd_addr_i(addr),
        .sel_x_i(sx), .sel_y_i(sy), .rd_data_o(rdata)
    );

    // vector: {arm, width[3:0], mode[1:0]}
    localparam int NV = 8;
    localparam logic [6:0] VEC [NV] = '{
        {1'b1, 4'd3, 2'b00},
        {1'b0, 4'd2, 2'b00},
        {1'b1, 4'd1, 2'b01},
        {1'b1, 4'd7, 2'b10},
        {1'b0, 4'd5, 2'b11},
        {1'b1, 4'd2, 2'b00},
        {1'b1, 4'd9, 2'b00},
        {1'b0, 4'd1, 2'b00}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm_write(input logic v);
        @(negedge clk);
        we = 1'b1; wd = v;
        @(negedge clk);
        we = 1'b0; wd = 1'b0;
    endtask

    // drive ext at a falling clock edge; returns counter value expected at capture
    task automatic drive_ext(input logic v, output logic [7:0] at_cap);
        @(negedge clk);
        ext = v;
        at_cap = cnt + 8'd2;
    endtask

    task automatic chk(input logic [1:0] a, input logic [1:0] mode,
                       input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a; sx = mode[0]; sy = mode[1];
        #1;
        n_chk++;
        if (rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%0d mode=%b actual=%h expected=%h", tag, a, mode, rdata, exp);
        end
        sx = 1'b0; sy = 1'b0;
    endtask

    logic done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] er, ef;
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1: reset values
        chk(2'd0, 2'b00, 8'h00, "R1 start bit");
        chk(2'd1, 2'b00, 8'h00, "R1 rise reg");
        chk(2'd2, 2'b00, 8'h00, "R1 fall reg");

        // table walk: R2, R3, R4, R5, R9, R10
        for (int v = 0; v < NV; v++) begin
            logic       a;
            logic [3:0] w;
            logic [1:0] m;
            {a, w, m} = VEC[v];
            if (a) begin
                arm_write(1'b1);
                chk(2'd0, m, 8'h01, "R9 start bit readable while armed");
            end
            tick(2);
            drive_ext(1'b1, er);
            tick(w - 1);
            drive_ext(1'b0, ef);
            tick(4);
            if (a) begin
                exp_rise = er;
                exp_fall = ef;
            end
            chk(2'd1, m, (m != 2'b00) ? 8'h00 : exp_rise, a ? "R3 R10 rise capture" : "R2 rise unchanged");
            chk(2'd2, m, (m != 2'b00) ? 8'h00 : exp_fall, a ? "R4 R10 fall capture" : "R2 fall unchanged");
            chk(2'd0, m, 8'h00, "R5 start bit self-clears");
            chk(2'd1, 2'b00, exp_rise, "R9 rise visible again");
        end

        // R5: extra pulse after completion changes nothing
        drive_ext(1'b1, er); tick(3); drive_ext(1'b0, ef); tick(4);
        chk(2'd1, 2'b00, exp_rise, "R5 no capture after completion");
        chk(2'd2, 2'b00, exp_fall, "R5 no capture after completion");

        // R6: falling edge before rise is ignored
        drive_ext(1'b1, er); tick(4);
        arm_write(1'b1);
        tick(1);
        drive_ext(1'b0, ef); tick(4);
        chk(2'd2, 2'b00, exp_fall, "R6 early fall ignored");
        chk(2'd0, 2'b00, 8'h01, "R6 still armed");
        drive_ext(1'b1, er); tick(2); drive_ext(1'b0, ef); tick(4);
        exp_rise = er; exp_fall = ef;
        chk(2'd1, 2'b00, exp_rise, "R6 rise after early fall");
        chk(2'd2, 2'b00, exp_fall, "R6 fall after early fall");

        // R7: restart while waiting for fall
        arm_write(1'b1);
        tick(1);
        drive_ext(1'b1, er); tick(4);
        exp_rise = er;
        arm_write(1'b1);
        drive_ext(1'b0, ef); tick(4);
        chk(2'd2, 2'b00, exp_fall, "R7 fall ignored after restart");
        chk(2'd0, 2'b00, 8'h01, "R7 still armed after restart");
        chk(2'd1, 2'b00, exp_rise, "R7 rise kept until next rise");
        drive_ext(1'b1, er); tick(3); drive_ext(1'b0, ef); tick(4);
        exp_rise = er; exp_fall = ef;
        chk(2'd1, 2'b00, exp_rise, "R7 rise after restart");
        chk(2'd2, 2'b00, exp_fall, "R7 fall after restart");
        chk(2'd0, 2'b00, 8'h00, "R7 disarmed after sequence");

        // R8: abort
        arm_write(1'b1);
        arm_write(1'b0);
        chk(2'd0, 2'b00, 8'h00, "R8 abort clears start bit");
        drive_ext(1'b1, er); tick(3); drive_ext(1'b0, ef); tick(4);
        chk(2'd1, 2'b00, exp_rise, "R8 rise unchanged after abort");
        chk(2'd2, 2'b00, exp_fall, "R8 fall unchanged after abort");

        // R9: address 3 and blocked reads
        chk(2'd3, 2'b00, 8'h00, "R9 unused address");
        chk(2'd2, 2'b11, 8'h00, "R9 fall blocked");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule